// File: doc/BRIEF.md
# Double-Buffered Four-Channel Analog Output Register Bank

This block sits on a 16-bit register bus and holds the digital side of four 12-bit analog output channels. Each channel has a staging register that software writes. A separate active register drives the converter code. In buffered mode, staged codes reach the active registers only when the host reads a dedicated update offset. All four channels then change on the same clock edge. Per-channel polarity and gain settings work the same way. A range word is staged by a write and applied by a read of its own offset.

A mode register sets whether the bank is enabled and whether data is buffered. With buffering off, a data write goes straight to the active register. While the bank is disabled, every channel outputs the midscale code. Reset clears the range settings and the mode register. Reads return no data; only their side effect matters.

Top module: `dacbank_top`

## Requirements
- R1: After reset, every channel code output is midscale 0x800, all bipolar and gain flags are 0, and the bank is disabled and unbuffered.
- R2: Channel n (0 to 3) stages its code by a write to byte offset 0x14 + 2*n. Only write data bits 11:0 are kept, and bits 15:12 are ignored.
- R3: In buffered mode, a staged write leaves the outputs unchanged. A read of offset 0x02 copies all four staged codes to the active registers on one clock edge, visible one cycle after the read.
- R4: With buffering off, a data write updates that channel's active code, visible one cycle after the write.
- R5: A write to offset 0x12 stages the range word. Bit 7-n is the bipolar flag and bit 11-n the gain flag of channel n. The flag outputs change only on a read of 0x12, one cycle after the read.
- R6: A write to offset 0x02 sets the mode: bit 1 enables the bank and bit 0 selects buffered mode. While disabled, all codes read 0x800. Re-enabling shows the held active codes again.
- R7: Writing zero to the mode register disables the bank. An asynchronous reset at any time clears the range flags and returns all outputs to midscale.
- R8: Reads and writes of any other offset change no output and no staged or active state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wdata | input | 16 | Write data |
| chan_code_o | output | 48 | Four 12-bit converter codes, channel 0 in bits 11:0 |
| bip_o | output | 4 | Bipolar flag per channel |
| gain_o | output | 4 | Gain flag per channel |

## Verification
The hardest case is a staged value that differs from the active value at the moment the mode or enable changes. A single sequence has to separate staged and active codes, flip buffering, and disable and re-enable the bank. If staged and active are ever equal, both views look the same at the outputs. Random accesses over all legal and several illegal offsets, with mode writes mixed in, keep staged and active codes diverged most of the time. Directed steps first force the key cases: upper data bits set, disable with pending staged data, and reset with pending range data.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
  localparam int BUS_AW   = 6;
  localparam int BUS_DW   = 16;
  localparam int CODE_W   = 12;
  localparam int NCH      = 4;   // range word layout holds at most four channels
  localparam logic [BUS_AW-1:0] OFS_MODE  = 6'h02;  // write: mode, read: data update
  localparam logic [BUS_AW-1:0] OFS_RANGE = 6'h12;  // write: stage, read: commit
  localparam logic [BUS_AW-1:0] OFS_DATA0 = 6'h14;  // channel n at +2n
  localparam int BIP_TOP  = 7;   // bipolar flag of channel n at BIP_TOP-n
  localparam int GAIN_TOP = 11;  // gain flag of channel n at GAIN_TOP-n
  localparam int MODE_EN_BIT  = 1;
  localparam int MODE_BUF_BIT = 0;
endpackage

// File: rtl/dacbank_decode.sv
module dacbank_decode
  import dacbank_pkg::*;
#(
  parameter int N_CH = NCH
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  output logic [N_CH-1:0]   data_we,
  output logic              mode_we,
  output logic              range_we,
  output logic              data_commit,
  output logic              range_commit
);
  logic rd_only;

  assign rd_only      = bus_rd && !bus_wr;
  assign mode_we      = bus_wr && (bus_addr == OFS_MODE);
  assign range_we     = bus_wr && (bus_addr == OFS_RANGE);
  assign data_commit  = rd_only && (bus_addr == OFS_MODE);
  assign range_commit = rd_only && (bus_addr == OFS_RANGE);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_dsel
    localparam logic [BUS_AW-1:0] CH_OFS = OFS_DATA0 + BUS_AW'(2 * ch);
    assign data_we[ch] = bus_wr && (bus_addr == CH_OFS);
  end
endmodule

// File: rtl/dacbank_dbuf.sv
module dacbank_dbuf #(
  parameter int           W       = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stage_we,
  input  logic         direct_we,
  input  logic         commit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] stage_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] act_q, act_d;
  logic         stage_en, act_en;

  always_comb begin
    stage_en = stage_we;
    stage_d  = wdata;
    act_en   = direct_we || commit;
    act_d    = direct_we ? wdata : stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= RST_VAL;
      act_q   <= RST_VAL;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (act_en)   act_q   <= act_d;
    end
  end

  assign stage_o  = stage_q;
  assign active_o = act_q;
endmodule

// File: rtl/dacbank_top.sv
module dacbank_top
  import dacbank_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int CODE_B = CODE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [BUS_AW-1:0]      bus_addr,
  input  logic [BUS_DW-1:0]      bus_wdata,
  output logic [N_CH*CODE_B-1:0] chan_code_o,
  output logic [N_CH-1:0]        bip_o,
  output logic [N_CH-1:0]        gain_o
);
  localparam logic [CODE_B-1:0] MID = CODE_B'(1) << (CODE_B - 1);
  localparam int RNG_W = 2 * N_CH;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic [N_CH-1:0] data_we;
  logic            mode_we, range_we, data_commit, range_commit;

  dacbank_decode #(.N_CH(N_CH)) decode_i (
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .data_we     (data_we),
    .mode_we     (mode_we),
    .range_we    (range_we),
    .data_commit (data_commit),
    .range_commit(range_commit)
  );

  // mode register
  logic en_q, en_d, buf_q, buf_d;
  always_comb begin
    en_d  = bus_wdata[MODE_EN_BIT];
    buf_d = bus_wdata[MODE_BUF_BIT];
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q  <= 1'b0;
      buf_q <= 1'b0;
    end else if (mode_we) begin
      en_q  <= en_d;
      buf_q <= buf_d;
    end
  end

  // per-channel code staging
  logic [CODE_B-1:0] act_code [N_CH];
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [CODE_B-1:0] stage_unused;
    dacbank_dbuf #(.W(CODE_B), .RST_VAL(MID)) dbuf_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .stage_we (data_we[ch]),
      .direct_we(data_we[ch] && !buf_q),
      .commit   (data_commit),
      .wdata    (bus_wdata[CODE_B-1:0]),
      .stage_o  (stage_unused),
      .active_o (act_code[ch])
    );
    assign chan_code_o[ch*CODE_B +: CODE_B] = en_q ? act_code[ch] : MID;
  end

  // range word: {gain[N_CH-1:0], bip[N_CH-1:0]}
  logic [RNG_W-1:0] range_wval, range_stage, range_act;
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_rsel
    assign range_wval[ch]        = bus_wdata[BIP_TOP - ch];
    assign range_wval[N_CH + ch] = bus_wdata[GAIN_TOP - ch];
  end

  dacbank_dbuf #(.W(RNG_W), .RST_VAL('0)) range_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .stage_we (range_we),
    .direct_we(1'b0),
    .commit   (range_commit),
    .wdata    (range_wval),
    .stage_o  (range_stage),
    .active_o (range_act)
  );

  assign bip_o  = range_act[N_CH-1:0];
  assign gain_o = range_act[RNG_W-1:N_CH];

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/dacbank_chk.sv
module dacbank_chk
  import dacbank_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int CODE_B = CODE_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [BUS_AW-1:0]      bus_addr,
  input logic [BUS_DW-1:0]      bus_wdata,
  input logic                   en_q,
  input logic                   buf_q,
  input logic [2*N_CH-1:0]      range_stage,
  input logic [N_CH*CODE_B-1:0] chan_code_o,
  input logic [N_CH-1:0]        bip_o,
  input logic [N_CH-1:0]        gain_o
);
  localparam logic [CODE_B-1:0] MID = CODE_B'(1) << (CODE_B - 1);

  logic rng_rd, upd_rd, mode_wr;
  assign rng_rd  = bus_rd && !bus_wr && bus_addr == OFS_RANGE;
  assign upd_rd  = bus_rd && !bus_wr && bus_addr == OFS_MODE;
  assign mode_wr = bus_wr && bus_addr == OFS_MODE;

  assert_midscale_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> chan_code_o == {N_CH{MID}});

  assert_range_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rng_rd |=> {gain_o, bip_o} == $past(range_stage));

  assert_range_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rng_rd |=> $stable({gain_o, bip_o}));

  assert_buffered_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && buf_q && !upd_rd && !mode_wr) |=> $stable(chan_code_o));

  assert_zero_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !bus_wdata[MODE_EN_BIT]) |=> !en_q);
endmodule

bind dacbank_top dacbank_chk #(.N_CH(N_CH), .CODE_B(CODE_B)) chk_i (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .en_q       (en_q),
  .buf_q      (buf_q),
  .range_stage(range_stage),
  .chan_code_o(chan_code_o),
  .bip_o      (bip_o),
  .gain_o     (gain_o)
);

// File: tb/dacbank_top_tb_top.sv
module dacbank_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [47:0] chan_code_o;
  logic [3:0]  bip_o, gain_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dacbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .chan_code_o(chan_code_o), .bip_o(bip_o), .gain_o(gain_o)
  );

  // reference model
  logic [11:0] m_stage [4];
  logic [11:0] m_act   [4];
  logic [15:0] m_rstage, m_ract;
  bit          m_en, m_buf;

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin m_stage[c] = 12'h800; m_act[c] = 12'h800; end
    m_rstage = '0; m_ract = '0; m_en = 0; m_buf = 0;
  endtask

  function automatic logic [47:0] exp_codes();
    logic [47:0] v;
    for (int c = 0; c < 4; c++) v[c*12 +: 12] = m_en ? m_act[c] : 12'h800;
    return v;
  endfunction

  function automatic logic [7:0] exp_flags();
    logic [7:0] v;
    for (int c = 0; c < 4; c++) begin
      v[c]     = m_rstage[0] === 1'bx ? 1'b0 : m_ract[7 - c];
      v[4 + c] = m_ract[11 - c];
    end
    return v;
  endfunction

  task automatic model_apply(input bit w, input logic [5:0] a, input logic [15:0] d);
    if (w) begin
      if (a == 6'h02) begin m_en = d[1]; m_buf = d[0]; end
      else if (a == 6'h12) m_rstage = d;
      else if (a >= 6'h14 && a <= 6'h1A && a[0] == 1'b0) begin
        int c = (a - 6'h14) / 2;
        m_stage[c] = d[11:0];
        if (!m_buf) m_act[c] = d[11:0];
      end
    end else begin
      if (a == 6'h02) for (int c = 0; c < 4; c++) m_act[c] = m_stage[c];
      else if (a == 6'h12) m_ract = m_rstage;
    end
  endtask

  task automatic bus_op(input bit w, input logic [5:0] a, input logic [15:0] d);
    bus_wr = w; bus_rd = !w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_wdata = '0; bus_addr = '0;
    model_apply(w, a, d);
  endtask

  task automatic check(input string tag);
    logic [47:0] ec;
    logic [7:0]  ef;
    ec = exp_codes();
    ef = exp_flags();
    n_checks++;
    if (chan_code_o !== ec || {gain_o, bip_o} !== ef) begin
      n_errors++;
      $display("FAIL %s: codes=%h flags=%h expected codes=%h flags=%h",
               tag, chan_code_o, {gain_o, bip_o}, ec, ef);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  localparam logic [5:0] ADDRS [10] = '{6'h02, 6'h02, 6'h12, 6'h14, 6'h16,
                                        6'h18, 6'h1A, 6'h04, 6'h10, 6'h15};

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    check("R1 reset state");

    // buffered, enabled
    bus_op(1, 6'h02, 16'h0003);
    check("R6 enable midscale held");
    bus_op(1, 6'h14, 16'hF123);
    bus_op(1, 6'h16, 16'h0456);
    bus_op(1, 6'h18, 16'hA789);
    bus_op(1, 6'h1A, 16'h0ABC);
    check("R3 staged writes not visible");
    bus_op(0, 6'h02, 16'h0000);
    check("R3 update read commits all");
    check("R2 upper data bits ignored");

    bus_op(0, 6'h04, 16'h0000);
    bus_op(1, 6'h04, 16'hFFFF);
    bus_op(1, 6'h00, 16'hFFFF);
    bus_op(0, 6'h14, 16'h0000);
    bus_op(1, 6'h15, 16'h0111);
    check("R8 other offsets no effect");
    bus_op(0, 6'h02, 16'h0000);
    check("R8 no hidden staging");

    bus_op(1, 6'h12, 16'h0A50);
    check("R5 range staged only");
    bus_op(0, 6'h12, 16'h0000);
    check("R5 range commit mapping");
    bus_op(1, 6'h12, 16'h05A0);
    bus_op(0, 6'h12, 16'h0000);
    check("R5 range commit second pattern");

    // unbuffered
    bus_op(1, 6'h02, 16'h0002);
    bus_op(1, 6'h18, 16'h0321);
    check("R4 direct write visible");

    // pending staged data, then disable
    bus_op(1, 6'h02, 16'h0003);
    bus_op(1, 6'h16, 16'h0FFF);
    bus_op(1, 6'h02, 16'h0000);
    check("R7 zero mode disables");
    check("R6 disabled midscale");
    bus_op(1, 6'h02, 16'h0003);
    check("R6 re-enable shows held codes");
    bus_op(0, 6'h02, 16'h0000);
    check("R3 pending staged after re-enable");

    // async reset with pending range
    bus_op(1, 6'h12, 16'h0FF0);
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    model_reset();
    check("R7 async reset clears outputs");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset clears range");
    bus_op(0, 6'h12, 16'h0000);
    check("R7 staged range cleared by reset");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  a;
      logic [15:0] d;
      bit          w;
      a = ADDRS[$urandom_range(0, 9)];
      d = 16'($urandom);
      w = ($urandom_range(0, 2) != 0);
      if (a == 6'h02 && w) d[1] = ($urandom_range(0, 5) != 0);
      bus_op(w, a, d);
      check("R3 random access");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule